// File: doc/BRIEF.md
# Split-Access Load-Store Unit

This block carries loads and stores from a computed byte address onto a 32-bit data bus that is addressed by words. The bus uses a request/grant handshake, byte-lane enables and one read-data beat per granted transaction. An access that fits inside one bus word goes out as a single transaction. A word access whose address is not a multiple of four, and a halfword access that starts at byte offset 3, cross a word boundary. The unit splits each of these into two transactions in hardware: first the lower word, then the word above it.

For stores, the store data is rotated by the byte offset so that every byte sits on the lane that matches its address. For loads, the returned words are joined in address order, shifted down to bit 0, and then sign- or zero-extended by the access size and the sign flag. The unit then presents the result for writeback.

The unit takes one access at a time. It raises `req_ready` only when idle, and it reports the end of each access with a single-cycle `rsp_valid` pulse. The size encoding is 0 for byte, 1 for halfword and 2 for word. The value 3 is reserved and is never issued.

Top module: `split_lsu`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `bus_req` is 0 and `rsp_valid` is 0.
- R2: An access that does not cross a word boundary makes exactly one bus transaction. Its address is the request address with bits 1:0 cleared, and its byte enables mark exactly the bytes accessed (byte: one lane, halfword: two lanes, word: 4'b1111).
- R3: A word access at offset 1, 2 or 3 makes two transactions. The first goes to the lower word with enables on lanes offset..3. The second goes to that address plus 4 with enables on lanes 0..offset-1.
- R4: A halfword access at offset 3 makes two transactions, with enables 4'b1000 on the lower word and 4'b0001 on the next word.
- R5: Once `bus_req` is raised, it stays high until `bus_gnt`, with `bus_addr`, `bus_be` and `bus_wdata` unchanged. The second transaction of a split access is requested only after the first has been granted.
- R6: For stores, `bus_we` is 1 and byte lane k of `bus_wdata` carries store-data byte (k - offset) mod 4. Every byte written in this way reads back through later loads.
- R7: A load returns the accessed bytes in little-endian order, with the byte at the lowest address in bits 7:0, including bytes taken from two bus words.
- R8: For byte and halfword loads, the upper bits of the result copy the top loaded bit when `req_signed` is 1 and are zero when it is 0. Word loads do not depend on `req_signed`.
- R9: `rsp_valid` pulses for one cycle, in the cycle after the last read-data beat of the access. `req_ready` is 1 exactly when the unit is idle, and this includes the cycle of `rsp_valid`.
- R10: Bits 1:0 of `bus_addr` are zero whenever `bus_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit is idle and accepts a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Sign-extend byte/halfword loads |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Access finished (one-cycle pulse) |
| rsp_rdata | output | 32 | Extended load result (0 for stores) |
| bus_req | output | 1 | Bus transaction request |
| bus_gnt | input | 1 | Bus grant for the current request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Lane-rotated write data |
| bus_rvalid | input | 1 | Read/response beat, one per granted transaction |
| bus_rdata | input | 32 | Read data for the beat |

## Verification
The assertions assume a well-behaved bus. Exactly one `bus_rvalid` beat must come back for each grant, beats must arrive in grant order, and no beat may arrive without an earlier grant. They also assume that `req_size` never takes the reserved value 3. The bench bus model grants on random cycles and returns each beat exactly one cycle after its grant. As a result, the first beat of a split access often lands while the second request is still waiting for its grant. Stimulus keeps sizes within 0..2 and addresses below 60, so that no access runs past the modelled memory.

// File: rtl/split_lsu_pkg.sv
package split_lsu_pkg;
    localparam int unsigned AW   = 32;
    localparam int unsigned DW   = 32;
    localparam int unsigned NB   = DW / 8;
    localparam int unsigned OFFW = $clog2(NB);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_DRAIN  = 2'd3
    } state_e;

    typedef struct packed {
        logic [NB-1:0] be_lo;
        logic [NB-1:0] be_hi;
        logic          split;
        logic [DW-1:0] wdata;
    } plan_t;

    function automatic logic [NB-1:0] size_mask(size_e s);
        case (s)
            SZ_BYTE: size_mask = NB'(1);
            SZ_HALF: size_mask = NB'(3);
            default: size_mask = '1;
        endcase
    endfunction
endpackage

// File: rtl/split_lsu_plan.sv
module split_lsu_plan
    import split_lsu_pkg::*;
(
    input  logic [OFFW-1:0] off_i,
    input  size_e           size_i,
    input  logic [DW-1:0]   wdata_i,
    output plan_t           plan_o
);
    logic [2*NB-1:0] lanes;
    logic [DW-1:0]   rot;

    // enables of both words: access mask slid up by the offset
    assign lanes = {{NB{1'b0}}, size_mask(size_i)} << off_i;

    always_comb begin
        rot = '0;
        for (int k = 0; k < NB; k++) begin
            logic [OFFW-1:0] src;
            src = OFFW'(k) - off_i;
            rot[k*8 +: 8] = wdata_i[{src, 3'b000} +: 8];
        end
    end

    assign plan_o.be_lo = lanes[NB-1:0];
    assign plan_o.be_hi = lanes[2*NB-1:NB];
    assign plan_o.split = |lanes[2*NB-1:NB];
    assign plan_o.wdata = rot;
endmodule

// File: rtl/split_lsu_merge.sv
module split_lsu_merge
    import split_lsu_pkg::*;
(
    input  logic [DW-1:0]   lo_i,
    input  logic [DW-1:0]   hi_i,
    input  logic [OFFW-1:0] off_i,
    input  size_e           size_i,
    input  logic            sgn_i,
    output logic [DW-1:0]   data_o
);
    logic [2*DW-1:0] joined;
    logic [DW-1:0]   raw;

    assign joined = {hi_i, lo_i} >> {off_i, 3'b000};
    assign raw    = joined[DW-1:0];

    always_comb begin
        case (size_i)
            SZ_BYTE: data_o = {{(DW-8){sgn_i & raw[7]}}, raw[7:0]};
            SZ_HALF: data_o = {{(DW-16){sgn_i & raw[15]}}, raw[15:0]};
            default: data_o = raw;
        endcase
    end
endmodule

// File: rtl/split_lsu.sv
module split_lsu
    import split_lsu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [1:0]    req_size,
    input  logic          req_signed,
    input  logic [31:0]   req_addr,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_we,
    output logic [31:0]   bus_addr,
    output logic [3:0]    bus_be,
    output logic [31:0]   bus_wdata,
    input  logic          bus_rvalid,
    input  logic [31:0]   bus_rdata
);
    state_e          state_q;
    plan_t           plan_d, plan_q;
    logic [AW-1:0]   base_q;
    logic [OFFW-1:0] off_q;
    size_e           size_q;
    logic            sgn_q, we_q, got_q;
    logic [DW-1:0]   lo_q, merged;
    logic            accept, first_beat, last_beat;

    split_lsu_plan u_plan (
        .off_i   (req_addr[OFFW-1:0]),
        .size_i  (size_e'(req_size)),
        .wdata_i (req_wdata),
        .plan_o  (plan_d)
    );

    split_lsu_merge u_merge (
        .lo_i   (plan_q.split ? lo_q : bus_rdata),
        .hi_i   (bus_rdata),
        .off_i  (off_q),
        .size_i (size_q),
        .sgn_i  (sgn_q),
        .data_o (merged)
    );

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign bus_req    = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign bus_we     = we_q;
    assign bus_addr   = (state_q == ST_SECOND) ? base_q + AW'(NB) : base_q;
    assign bus_be     = (state_q == ST_SECOND) ? plan_q.be_hi : plan_q.be_lo;
    assign bus_wdata  = plan_q.wdata;
    assign first_beat = bus_rvalid && plan_q.split && !got_q;
    assign last_beat  = bus_rvalid && (!plan_q.split || got_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            plan_q    <= '0;
            base_q    <= '0;
            off_q     <= '0;
            size_q    <= SZ_BYTE;
            sgn_q     <= 1'b0;
            we_q      <= 1'b0;
            got_q     <= 1'b0;
            lo_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_FIRST;
                    plan_q  <= plan_d;
                    base_q  <= {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
                    off_q   <= req_addr[OFFW-1:0];
                    size_q  <= size_e'(req_size);
                    sgn_q   <= req_signed;
                    we_q    <= req_we;
                    got_q   <= 1'b0;
                end
                ST_FIRST:  if (bus_gnt) state_q <= plan_q.split ? ST_SECOND : ST_DRAIN;
                ST_SECOND: if (bus_gnt) state_q <= ST_DRAIN;
                default: ;
            endcase
            if (first_beat) begin
                lo_q  <= bus_rdata;
                got_q <= 1'b1;
            end
            if (last_beat && state_q == ST_DRAIN) begin
                state_q   <= ST_IDLE;
                rsp_valid <= 1'b1;
                rsp_rdata <= we_q ? '0 : merged;
            end
        end
    end

    AST_ADDR_WORD: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> bus_addr[1:0] == 2'b00);  // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata));  // R5
    AST_BE_PRESENT: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> bus_be != 4'b0000);  // R2
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);  // R9
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready && !bus_req);  // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready && bus_req);  // R9
endmodule

// File: tb/split_lsu_bench.sv
`timescale 1ns/1ps
module split_lsu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_we = 1'b0, req_signed = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, bus_req, bus_we;
    logic [31:0] rsp_rdata, bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_gnt, bus_rvalid;
    logic [31:0] bus_rdata;

    always #2 clk = ~clk;

    split_lsu u_split_lsu (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_size(req_size), .req_signed(req_signed),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    int n_cmp = 0, n_bad = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    typedef struct {
        bit          is_load;
        logic [31:0] data;
        int          n;
        logic [31:0] a0;
        logic [3:0]  be0, be1;
        string       dtag, ntag;
    } item_t;
    item_t       sb[$];
    logic [31:0] g_addr[$];
    logic [3:0]  g_be[$];

    logic [7:0] bmem[64];
    logic [7:0] smem[64];

    // bus model: random grant, one beat one cycle after each grant
    logic        pend_q = 1'b0;
    logic [31:0] pa_q;
    logic [3:0]  pb_q;
    always @(posedge clk) begin
        if (rst) begin
            bus_gnt <= 1'b0; bus_rvalid <= 1'b0; bus_rdata <= '0; pend_q <= 1'b0;
        end else begin
            if (pend_q && bus_req)
                check(bus_addr == pa_q && bus_be == pb_q, "R5", "held request", {bus_be, bus_addr[27:0]}, {pb_q, pa_q[27:0]});
            pend_q <= bus_req && !bus_gnt;
            pa_q <= bus_addr; pb_q <= bus_be;
            bus_rvalid <= 1'b0;
            if (bus_req && bus_gnt) begin
                g_addr.push_back(bus_addr);
                g_be.push_back(bus_be);
                bus_rvalid <= 1'b1;
                for (int k = 0; k < 4; k++) begin
                    bus_rdata[k*8 +: 8] <= bmem[{bus_addr[5:2], 2'(k)}];
                    if (bus_we && bus_be[k]) bmem[{bus_addr[5:2], 2'(k)}] <= bus_wdata[k*8 +: 8];
                end
            end
            bus_gnt <= ($urandom % 3) != 0;
        end
    end

    // monitor
    logic prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                item_t it;
                check(!prev_rsp, "R9", "rsp pulse width", 32'(prev_rsp), 0);
                check(req_ready, "R9", "ready with rsp", 32'(req_ready), 1);
                if (sb.size() == 0) begin
                    check(0, "R9", "unexpected rsp", 1, 0);
                end else begin
                    it = sb.pop_front();
                    check(g_addr.size() == it.n, it.ntag, "transaction count", g_addr.size(), it.n);
                    if (g_addr.size() > 0) begin
                        check(g_addr[0] == it.a0, "R10", "first address", g_addr[0], it.a0);
                        check(g_be[0] == it.be0, it.ntag, "first enables", g_be[0], it.be0);
                    end
                    if (it.n == 2 && g_addr.size() == 2) begin
                        check(g_addr[1] == it.a0 + 4, it.ntag, "second address", g_addr[1], it.a0 + 4);
                        check(g_be[1] == it.be1, it.ntag, "second enables", g_be[1], it.be1);
                    end
                    if (it.is_load)
                        check(rsp_rdata == it.data, it.dtag, "load data", rsp_rdata, it.data);
                    g_addr.delete();
                    g_be.delete();
                end
            end
            prev_rsp <= rsp_valid;
        end
    end

    task automatic do_op(input bit we, input int size, input bit sgn,
                         input logic [31:0] a, input logic [31:0] wd, input string dtag);
        item_t it;
        int nb = 1 << size;
        int off = a % 4;
        logic [7:0] lanes = 8'((1 << nb) - 1) << off;
        logic [31:0] v = '0;
        it.is_load = !we;
        it.n   = (off + nb > 4) ? 2 : 1;
        it.a0  = a & 32'hFFFF_FFFC;
        it.be0 = lanes[3:0];
        it.be1 = lanes[7:4];
        it.ntag = (it.n == 1) ? "R2" : (size == 2 ? "R3" : "R4");
        for (int i = 0; i < nb; i++) begin
            if (we) smem[(a + i) % 64] = wd[i*8 +: 8];
            else    v[i*8 +: 8] = smem[(a + i) % 64];
        end
        if (!we && sgn && size < 2 && v[nb*8-1]) begin
            for (int i = nb*8; i < 32; i++) v[i] = 1'b1;
        end
        it.data = v;
        it.dtag = dtag;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b1; req_we = we; req_size = 2'(size); req_signed = sgn;
        req_addr = a; req_wdata = wd;
        sb.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            bmem[i] = 8'((i * 37 + 5) & 255);
            smem[i] = 8'((i * 37 + 5) & 255);
        end
        repeat (3) @(negedge clk);
        check(req_ready && !bus_req && !rsp_valid, "R1", "reset state", {req_ready, bus_req, rsp_valid}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !bus_req && !rsp_valid, "R1", "after reset", {req_ready, bus_req, rsp_valid}, 3'b100);
        // every size at every offset, signed and unsigned loads (R7, R8)
        for (int s = 0; s < 3; s++)
            for (int o = 0; o < 4; o++) begin
                do_op(0, s, 0, 32'(16 + o), 0, "R7");
                do_op(0, s, 1, 32'(16 + o), 0, (s < 2) ? "R8" : "R7");
            end
        // stores with rotation, then reads back (R6)
        for (int s = 0; s < 3; s++)
            for (int o = 0; o < 4; o++) begin
                do_op(1, s, 0, 32'(32 + o), 32'h8D7E_F1A2 ^ 32'(s * 16 + o), "R6");
                do_op(0, 2, 0, 32'(32), 0, "R6");
                do_op(0, 2, 0, 32'(36), 0, "R6");
                do_op(0, s, 1, 32'(32 + o), 0, "R6");
            end
        // negative halfword across boundary, byte sign bit (R8)
        do_op(1, 1, 0, 32'd7, 32'h0000_80FF, "R6");
        do_op(0, 1, 1, 32'd7, 0, "R8");
        do_op(0, 1, 0, 32'd7, 0, "R8");
        do_op(0, 0, 1, 32'd8, 0, "R8");
        for (int i = 0; i < 300; i++)
            do_op($urandom % 2, $urandom % 3, $urandom % 2, 32'($urandom % 60), $urandom, "R7");
        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R9", "responses outstanding", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R9", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule